// File: doc/BRIEF.md
# Set-Associative Victim Selector

This block chooses which way of a set-associative cache set is overwritten when an access misses. It has a parallel tag comparator across all ways of the indexed set, and it holds replacement state for each set. Each cycle it presents the set index and tag of an access together with the stored tags and valid bits that the tag array reads out for that set. The block returns a hit flag, the matching way, and the way to be refilled on a miss. The tag and data arrays, the refill path and the write policy sit outside the block. The caller writes the new tag into the reported victim way when it handles a miss.

A build-time parameter selects the replacement policy: least-recently-used, first-in-first-out (least-recently-replaced) or reproducible pseudo-random. A free way always takes priority over the policy. Each valid access falls into one of three named access kinds, and these drive the state update. ACC_IDLE means no valid access, and the state holds. ACC_HIT means a valid access that matched; the transition refreshes the way under LRU and changes nothing under FIFO or random. ACC_FILL means a valid access that missed; the transition records the victim as filled. The replacement state moves on the clock edge that ends the access cycle. All outputs are combinational from the current state and the inputs.

Top module: `vs_victim_top`

## Requirements
- R1: `hit` is 1 exactly when some way with its valid bit set holds a tag equal to `acc_tag`. `hit_way` is then the lowest such way index.
- R2: If any way of the presented set is invalid, `victim_way` is the lowest-numbered invalid way, whatever the policy.
- R3: LRU policy, all ways valid: `victim_way` is the way with the highest age in the set. After reset, way i of every set has age i, so way WAYS-1 is the first LRU victim.
- R4: LRU policy: a hit, and also a fill into the victim way, gives the touched way age 0. Every way whose age was below the touched way's old age then ages by one.
- R5: FIFO policy, all ways valid: `victim_way` equals the per-set pointer. The pointer resets to 0 and advances by one, modulo WAYS, on every fill of its set.
- R6: FIFO policy: a hit leaves the pointer unchanged.
- R7: Random policy, all ways valid: `victim_way` is the low log2(WAYS) bits of a 16-bit LFSR. The LFSR resets to 0xACE1 and steps once per miss by shifting right; when the bit shifted out is 1, it is XORed with 0xB400.
- R8: While `acc_valid` is 0, no replacement state changes, whatever tags are presented.
- R9: State updates touch only the set given by `acc_set`; the other sets keep their LRU ages and FIFO pointers. (The LFSR is shared.)
- R10: After reset, with all ways valid and no hit, the victim is way WAYS-1 under LRU, way 0 under FIFO, and the low bits of 0xACE1 under random.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| way_tags | input | WAYS*TAG_W | Stored tags of the set, way w at bits [w*TAG_W +: TAG_W] |
| way_valid | input | WAYS | Valid bit per way of the set |
| hit | output | 1 | Tag matched in a valid way |
| hit_way | output | WAY_W | Lowest matching way |
| victim_way | output | WAY_W | Way to refill on a miss |

## Verification
The bench builds three copies side by side, each with four ways, four sets and six-bit tags: u0 uses LRU, u1 uses FIFO and u2 uses random. All three receive the same set and tag stream. The tag range is narrow enough that hits, cold misses into free ways and conflict evictions all occur often, so every age permutation and pointer position is visited across all sets. With four ways, every LRU age value and every FIFO wrap shows up within a few fills. Directed steps isolate the reset victims, idle cycles carrying miss-looking tags, and updates confined to one set.

// File: rtl/vs_pkg.sv
package vs_pkg;

    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2
    } repl_policy_e;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/vs_tag_cmp.sv
module vs_tag_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [TAG_W-1:0]      tag,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/vs_lfsr.sv
module vs_lfsr #(
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_nxt;

    always_comb begin
        state_nxt = state_q >> 1;
        if (state_q[0]) begin
            state_nxt = state_nxt ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    assign state = state_q;

    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    a_r7_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/vs_repl_state.sv
module vs_repl_state
    import vs_pkg::*;
#(
    parameter repl_policy_e POLICY = POL_LRU,
    parameter int           WAYS   = 4,
    parameter int           SETS   = 4,
    parameter int           LFSR_W = 16,
    localparam int          WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int          SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAY_W-1:0] pol_way
);

    if (POLICY == POL_LRU) begin : g_lru
        logic [WAY_W-1:0]      age_q   [SETS][WAYS];
        logic [WAY_W-1:0]      age_nxt [WAYS];
        logic [WAY_W-1:0]      old_age;
        logic [WAYS-1:0]       oldest;
        logic [SETS*WAYS*WAY_W-1:0] age_flat;

        always_comb begin
            old_age = age_q[upd_set][upd_way];
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    age_nxt[w] = '0;
                end else if (age_q[upd_set][w] < old_age) begin
                    age_nxt[w] = age_q[upd_set][w] + 1'b1;
                end else begin
                    age_nxt[w] = age_q[upd_set][w];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        age_q[s][w] <= WAY_W'(w);
                    end
                end
            end else if (kind != ACC_IDLE) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[upd_set][w] <= age_nxt[w];
                end
            end
        end

        always_comb begin
            pol_way = '0;
            for (int w = 0; w < WAYS; w++) begin
                oldest[w] = (age_q[upd_set][w] == WAY_W'(WAYS - 1));
            end
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (oldest[w]) begin
                    pol_way = WAY_W'(w);
                end
            end
        end

        for (genvar s = 0; s < SETS; s++) begin : g_fs
            for (genvar w = 0; w < WAYS; w++) begin : g_fw
                assign age_flat[(s*WAYS+w)*WAY_W +: WAY_W] = age_q[s][w];
            end
        end

        a_r3_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest) == 1);

        a_r4_touched_youngest: assert property (@(posedge clk) disable iff (!rst_n)
            (kind != ACC_IDLE && upd_set == '0 && upd_way == '0) |=> age_flat[WAY_W-1:0] == '0);

        a_r8_lru_hold: assert property (@(posedge clk) disable iff (!rst_n)
            kind == ACC_IDLE |=> $stable(age_flat));

    end else if (POLICY == POL_FIFO) begin : g_fifo
        logic [WAY_W-1:0]      ptr_q [SETS];
        logic [SETS*WAY_W-1:0] ptr_flat;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    ptr_q[s] <= '0;
                end
            end else if (kind == ACC_FILL) begin
                if (ptr_q[upd_set] == WAY_W'(WAYS - 1)) begin
                    ptr_q[upd_set] <= '0;
                end else begin
                    ptr_q[upd_set] <= ptr_q[upd_set] + 1'b1;
                end
            end
        end

        assign pol_way = ptr_q[upd_set];

        for (genvar s = 0; s < SETS; s++) begin : g_fs
            assign ptr_flat[s*WAY_W +: WAY_W] = ptr_q[s];
        end

        a_r5_fill_moves: assert property (@(posedge clk) disable iff (!rst_n)
            kind == ACC_FILL |=> ptr_flat != $past(ptr_flat));

        a_r6_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
            kind != ACC_FILL |=> $stable(ptr_flat));

    end else begin : g_rand
        logic [LFSR_W-1:0] lfsr_state;

        vs_lfsr #(
            .LFSR_W (LFSR_W)
        ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (kind == ACC_FILL),
            .state (lfsr_state)
        );

        assign pol_way = lfsr_state[WAY_W-1:0];
    end

endmodule

// File: rtl/vs_victim_top.sv
module vs_victim_top
    import vs_pkg::*;
#(
    parameter repl_policy_e POLICY = POL_LRU,
    parameter int           WAYS   = 4,
    parameter int           SETS   = 4,
    parameter int           TAG_W  = 6,
    parameter int           LFSR_W = 16,
    localparam int          WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int          SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [SET_W-1:0]      acc_set,
    input  logic [TAG_W-1:0]      acc_tag,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      victim_way
);

    acc_kind_e        kind;
    logic [WAY_W-1:0] pol_way;
    logic [WAY_W-1:0] free_way;
    logic             free_any;
    logic [WAY_W-1:0] upd_way;

    vs_tag_cmp #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_cmp (
        .tag       (acc_tag),
        .way_tags  (way_tags),
        .way_valid (way_valid),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

    assign free_any   = ~&way_valid;
    assign victim_way = free_any ? free_way : pol_way;

    always_comb begin
        unique case ({acc_valid, hit})
            2'b11:   kind = ACC_HIT;
            2'b10:   kind = ACC_FILL;
            default: kind = ACC_IDLE;
        endcase
    end

    always_comb begin
        unique case (kind)
            ACC_HIT:  upd_way = hit_way;
            ACC_FILL: upd_way = victim_way;
            default:  upd_way = '0;
        endcase
    end

    vs_repl_state #(
        .POLICY (POLICY),
        .WAYS   (WAYS),
        .SETS   (SETS),
        .LFSR_W (LFSR_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .upd_set (acc_set),
        .upd_way (upd_way),
        .pol_way (pol_way)
    );

    a_r1_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (way_valid[hit_way] && way_tags[hit_way*TAG_W +: TAG_W] == acc_tag));

    a_r2_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
        free_any |-> !way_valid[victim_way]);

endmodule

// File: tb/sim_vs_victim_top.sv
module sim_vs_victim_top;
    import vs_pkg::*;

    localparam int WAYS = 4;
    localparam int SETS = 4;
    localparam int TAG_W = 6;
    localparam int WAY_W = 2;
    localparam int SET_W = 2;
    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic acc_valid;
    logic [SET_W-1:0] acc_set;
    logic [TAG_W-1:0] acc_tag;
    logic [WAYS*TAG_W-1:0] wt [3];
    logic [WAYS-1:0] wv [3];
    logic hit [3];
    logic [WAY_W-1:0] hw [3];
    logic [WAY_W-1:0] vic [3];

    vs_victim_top #(.POLICY(POL_LRU), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tag(acc_tag),
        .way_tags(wt[0]), .way_valid(wv[0]), .hit(hit[0]), .hit_way(hw[0]), .victim_way(vic[0]));
    vs_victim_top #(.POLICY(POL_FIFO), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tag(acc_tag),
        .way_tags(wt[1]), .way_valid(wv[1]), .hit(hit[1]), .hit_way(hw[1]), .victim_way(vic[1]));
    vs_victim_top #(.POLICY(POL_RAND), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tag(acc_tag),
        .way_tags(wt[2]), .way_valid(wv[2]), .hit(hit[2]), .hit_way(hw[2]), .victim_way(vic[2]));

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int mtag [3][SETS][WAYS];
    bit mval [3][SETS][WAYS];
    int mage [SETS][WAYS];
    int mptr [SETS];
    logic [15:0] mlfsr;

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int free_way(int p, int s);
        for (int w = 0; w < WAYS; w++) if (!mval[p][s][w]) return w;
        return -1;
    endfunction

    function automatic int exp_victim(int p, int s);
        int f = free_way(p, s);
        if (f >= 0) return f;
        if (p == 0) begin
            for (int w = 0; w < WAYS; w++) if (mage[s][w] == WAYS - 1) return w;
            return -1;
        end
        if (p == 1) return mptr[s];
        return int'(mlfsr[WAY_W-1:0]);
    endfunction

    function automatic int exp_hitway(int p, int s, int t);
        for (int w = 0; w < WAYS; w++) if (mval[p][s][w] && mtag[p][s][w] == t) return w;
        return -1;
    endfunction

    function automatic void lru_touch(int s, int w);
        int old = mage[s][w];
        for (int x = 0; x < WAYS; x++) begin
            if (x == w) mage[s][x] = 0;
            else if (mage[s][x] < old) mage[s][x]++;
        end
    endfunction

    function automatic logic [15:0] lfsr_next(logic [15:0] v);
        logic [15:0] n = v >> 1;
        if (v[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    function automatic string vic_tag(int p, int s);
        if (free_way(p, s) >= 0) return "R2";
        if (p == 0) return "R3 R4";
        if (p == 1) return "R5 R6";
        return "R7";
    endfunction

    task automatic present(int s, int t, bit v);
        acc_valid = v;
        acc_set = SET_W'(s);
        acc_tag = TAG_W'(t);
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < WAYS; w++) begin
                wt[p][w*TAG_W +: TAG_W] = TAG_W'(mtag[p][s][w]);
                wv[p][w] = mval[p][s][w];
            end
        end
    endtask

    // one access: drive at negedge, check mid-cycle, update model after the edge
    task automatic step(int s, int t, bit v, string lab);
        int ehw [3];
        int evc [3];
        present(s, t, v);
        #1;
        for (int p = 0; p < 3; p++) begin
            ehw[p] = exp_hitway(p, s, t);
            evc[p] = exp_victim(p, s);
            check({"R1 hit ", lab}, int'(hit[p]), int'(ehw[p] >= 0));
            if (ehw[p] >= 0) check({"R1 hit_way ", lab}, int'(hw[p]), ehw[p]);
            check({vic_tag(p, s), " victim ", lab}, int'(vic[p]), evc[p]);
        end
        @(posedge clk);
        if (v) begin
            for (int p = 0; p < 3; p++) begin
                if (ehw[p] >= 0) begin
                    if (p == 0) lru_touch(s, ehw[p]);
                end else begin
                    mtag[p][s][evc[p]] = t;
                    mval[p][s][evc[p]] = 1'b1;
                    if (p == 0) lru_touch(s, evc[p]);
                    if (p == 1) mptr[s] = (mptr[s] + 1) % WAYS;
                    if (p == 2) mlfsr = lfsr_next(mlfsr);
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED1234);
        for (int p = 0; p < 3; p++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    mtag[p][s][w] = 0;
                    mval[p][s][w] = 1'b0;
                end
        for (int s = 0; s < SETS; s++) begin
            mptr[s] = 0;
            for (int w = 0; w < WAYS; w++) mage[s][w] = w;
        end
        mlfsr = SEED;
        present(0, 0, 1'b0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset victims with every way forced valid and no matching tag
        acc_valid = 1'b0;
        acc_tag = TAG_W'(63);
        for (int p = 0; p < 3; p++) begin
            wv[p] = '1;
            wt[p] = '0;
        end
        #1;
        check("R10 lru reset victim", int'(vic[0]), WAYS - 1);
        check("R10 fifo reset victim", int'(vic[1]), 0);
        check("R10 rand reset victim", int'(vic[2]), int'(SEED[WAY_W-1:0]));
        check("R10 no hit", int'(hit[0]), 0);
        @(negedge clk);

        // R2: cold set, all ways free
        step(3, 1, 1'b0, "R2 cold");

        // R9: fill set 1 fully and beyond, then set 0 must still be cold
        for (int i = 0; i < 6; i++) step(1, 10 + i, 1'b1, "R9 fill set1");
        step(0, 40, 1'b0, "R9 other set untouched");

        // R8: idle cycles with miss-looking tags change nothing
        step(1, 50, 1'b0, "R8 idle a");
        step(1, 51, 1'b0, "R8 idle b");
        step(1, 52, 1'b1, "R8 after idle");

        // R6 R4: repeated hits on set 1 then a miss
        step(1, 52, 1'b1, "R6 hit");
        step(1, 15, 1'b1, "R4 hit");
        step(1, 53, 1'b1, "R6 miss after hits");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int s = int'($urandom_range(0, SETS - 1));
            int t = int'($urandom_range(0, 5));
            bit v = ($urandom_range(0, 9) != 0);
            step(s, t, v, "random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule